// File: doc/BRIEF.md
# Dual-Mixer Beat-Edge Phase Meter

This block measures the phase offset between two clocks that share a nominal frequency, for example a local reference and a clock recovered from a serial link. A third helper clock runs slightly off that frequency. Both input clocks are sampled as plain data in the helper domain. Each sampled stream is a slow beat waveform. The spacing between matching beat edges is the input phase offset multiplied by the ratio of the clock frequency to the frequency offset, so a coarse counter in the helper domain can resolve it.

Each beat goes through a short synchronizer chain and a run-length deglitcher. A free-running helper-domain counter timestamps the accepted rising edges. At each link-beat rising edge that follows a reference-beat rising edge, the block takes the difference of the two timestamps modulo the beat period. It folds that difference into a signed window around zero and emits it as a phase word with a one-cycle strobe. An optional stage averages 2^k consecutive measurements before output. The word is meant to feed an external delay-trimming loop.

Top module: `ddmtd_phase_meter`

## Requirements
- R1: While rst_n is low, and on the first helper cycle after it, phase_vld is 0 and phase_word is 0.
- R2: If the link beat rises d helper cycles after the reference beat (0 <= d < ceil(P/2), where P = cfg_beat_len), each measurement equals +d.
- R3: If the link beat rises d helper cycles before the reference beat (0 < d <= floor(P/2)), each measurement equals -d.
- R4: A raw separation s (0 <= s < P) is reported as s when s < ceil(P/2) and as s - P otherwise. Every output therefore lies in [-floor(P/2), ceil(P/2)-1]. For P = 64, a separation of 31 gives +31 and a separation of 32 gives -32.
- R5: phase_vld is a single-cycle pulse. With averaging off it pulses exactly once per beat period, so 8 periods give 8 pulses.
- R6: A level change on a sampled beat is accepted only after N consecutive equal samples, where N = cfg_glitch_len and a value of 0 acts as 1. A 2-sample pulse is ignored when N = 4 and accepted as a real edge when N = 1.
- R7: With k = cfg_avg_log2 (clamped to AVG_MAX_LOG2), one output is produced per 2^k measurements, equal to the mean of those measurements. With k = 2, 8 periods give 2 pulses.
- R8: The averaged mean is rounded toward minus infinity (arithmetic shift), so the mean of -3 and -4 is reported as -4.
- R9: A link-beat edge produces a measurement only if a reference-beat edge was accepted since the previous measurement (or since reset). With the reference beat held low, no pulses appear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_hlp | input | 1 | Helper (offset-frequency) clock; all logic runs on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_ref_in | input | 1 | Reference clock, sampled as data |
| clk_lnk_in | input | 1 | Recovered link clock, sampled as data |
| cfg_beat_len | input | TS_W | Beat period P in helper cycles |
| cfg_glitch_len | input | GLT_W | Deglitch run length N |
| cfg_avg_log2 | input | K_W | Averaging exponent k |
| phase_word | output | TS_W | Signed phase measurement, in helper cycles |
| phase_vld | output | 1 | One-cycle strobe qualifying phase_word |

## Verification
The sampled beats are driven as square waves with a period of 64 helper cycles, with the link beat displaced by small positive and small negative offsets and by offsets on both sides of the fold point. These patterns separate a correct sign convention and fold threshold from an off-by-one or a reversed subtraction.

A narrow pulse is injected between a reference edge and a link edge. It is run once with a long deglitch run length and once with a run length of one, which shows whether the filter really gates edges.

For averaging, the offsets alternate from period to period. A pair of 3 and 5 exposes a wrong group size, and a pair of -3 and -4 exposes truncation toward zero. A run with the reference beat held low shows whether unpaired link edges are rejected.

// File: rtl/ddmtd_pkg.sv
package ddmtd_pkg;
   localparam int unsigned NUM_CH   = 2;
   localparam int unsigned SYNC_MIN = 2;

   typedef enum logic {
      CH_REF = 1'b0,
      CH_LNK = 1'b1
   } ddmtd_ch_e;
endpackage

// File: rtl/ddmtd_beat_cond.sv
module ddmtd_beat_cond #(
   parameter int unsigned SYNC_STAGES = 3,
   parameter int unsigned GLT_W       = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             beat_in,
   input  logic [GLT_W-1:0] cfg_run_len,
   output logic             rise_o
);
   logic [SYNC_STAGES-1:0] chain_q;
   logic                   samp;
   logic                   level_q;
   logic [GLT_W-1:0]       run_q;
   logic [GLT_W-1:0]       run_eff;
   logic                   run_done;

   generate
      if (SYNC_STAGES == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= beat_in;
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[SYNC_STAGES-2:0], beat_in};
         end
      end
   endgenerate

   assign samp     = chain_q[SYNC_STAGES-1];
   assign run_eff  = (cfg_run_len == '0) ? GLT_W'(1) : cfg_run_len;
   assign run_done = ({1'b0, run_q} + 1'b1) >= {1'b0, run_eff};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level_q <= 1'b0;
         run_q   <= '0;
         rise_o  <= 1'b0;
      end else begin
         rise_o <= 1'b0;
         if (samp == level_q) begin
            run_q <= '0;
         end else if (run_done) begin
            level_q <= samp;
            run_q   <= '0;
            rise_o  <= samp;
         end else begin
            run_q <= run_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/ddmtd_edge_pair.sv
module ddmtd_edge_pair #(
   parameter int unsigned TS_W = 16
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   rise_ref,
   input  logic                   rise_lnk,
   input  logic [TS_W-1:0]        beat_len,
   output logic signed [TS_W-1:0] meas_word,
   output logic                   meas_vld
);
   logic [TS_W-1:0] ts_q;
   logic [TS_W-1:0] ts_ref_q;
   logic            armed_q;
   logic [TS_W-1:0] ts_ref_eff;
   logic [TS_W-1:0] sep;
   logic [TS_W-1:0] half_up;
   logic            pair_ok;
   logic [TS_W-1:0] folded;

   assign ts_ref_eff = rise_ref ? ts_q : ts_ref_q;
   assign sep        = ts_q - ts_ref_eff;
   assign half_up    = beat_len - (beat_len >> 1);
   assign pair_ok    = rise_lnk && (armed_q || rise_ref);
   assign folded     = (sep >= half_up) ? (sep - beat_len) : sep;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ts_q      <= '0;
         ts_ref_q  <= '0;
         armed_q   <= 1'b0;
         meas_word <= '0;
         meas_vld  <= 1'b0;
      end else begin
         ts_q     <= ts_q + 1'b1;
         meas_vld <= pair_ok;
         if (rise_ref) ts_ref_q <= ts_q;
         if (pair_ok)       armed_q <= 1'b0;
         else if (rise_ref) armed_q <= 1'b1;
         if (pair_ok) meas_word <= $signed(folded);
      end
   end
endmodule

// File: rtl/ddmtd_avg.sv
module ddmtd_avg #(
   parameter int unsigned TS_W         = 16,
   parameter int unsigned AVG_MAX_LOG2 = 4,
   parameter int unsigned K_W          = 3
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic signed [TS_W-1:0] in_word,
   input  logic                   in_vld,
   input  logic [K_W-1:0]         cfg_k,
   output logic signed [TS_W-1:0] out_word,
   output logic                   out_vld
);
   generate
      if (AVG_MAX_LOG2 == 0) begin : g_direct
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               out_word <= '0;
               out_vld  <= 1'b0;
            end else begin
               out_vld <= in_vld;
               if (in_vld) out_word <= in_word;
            end
         end
      end else begin : g_accum
         localparam int unsigned ACC_W = TS_W + AVG_MAX_LOG2;
         localparam int unsigned CNT_W = AVG_MAX_LOG2 + 1;

         logic [K_W-1:0]          k_eff;
         logic [CNT_W-1:0]        cnt_q;
         logic [CNT_W-1:0]        cnt_nxt;
         logic [CNT_W-1:0]        group_len;
         logic signed [ACC_W-1:0] acc_q;
         logic signed [ACC_W-1:0] acc_sum;
         logic signed [ACC_W-1:0] acc_mean;
         logic                    group_end;

         assign k_eff     = (cfg_k > K_W'(AVG_MAX_LOG2)) ? K_W'(AVG_MAX_LOG2) : cfg_k;
         assign cnt_nxt   = cnt_q + 1'b1;
         assign group_len = CNT_W'(1) << k_eff;
         assign group_end = (cnt_nxt == group_len);
         assign acc_sum   = acc_q + ACC_W'(in_word);
         assign acc_mean  = acc_sum >>> k_eff;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q    <= '0;
               acc_q    <= '0;
               out_word <= '0;
               out_vld  <= 1'b0;
            end else begin
               out_vld <= 1'b0;
               if (in_vld) begin
                  if (group_end) begin
                     cnt_q    <= '0;
                     acc_q    <= '0;
                     out_vld  <= 1'b1;
                     out_word <= acc_mean[TS_W-1:0];
                  end else begin
                     cnt_q <= cnt_nxt;
                     acc_q <= acc_sum;
                  end
               end
            end
         end
      end
   endgenerate
endmodule

// File: rtl/ddmtd_phase_meter.sv
module ddmtd_phase_meter #(
   parameter int unsigned TS_W         = 16,
   parameter int unsigned GLT_W        = 4,
   parameter int unsigned SYNC_STAGES  = 3,
   parameter int unsigned AVG_MAX_LOG2 = 4,
   parameter int unsigned K_W          = 3
) (
   input  logic                   clk_hlp,
   input  logic                   rst_n,
   input  logic                   clk_ref_in,
   input  logic                   clk_lnk_in,
   input  logic [TS_W-1:0]        cfg_beat_len,
   input  logic [GLT_W-1:0]       cfg_glitch_len,
   input  logic [K_W-1:0]         cfg_avg_log2,
   output logic signed [TS_W-1:0] phase_word,
   output logic                   phase_vld
);
   import ddmtd_pkg::*;

   localparam int unsigned K_NEED = (AVG_MAX_LOG2 == 0) ? 1 : $clog2(AVG_MAX_LOG2 + 1);

   generate
      if (TS_W < 4)                 begin : g_bad_ts   $error("TS_W must be at least 4");              end
      if (SYNC_STAGES < SYNC_MIN)   begin : g_bad_sync $error("SYNC_STAGES below synchronizer minimum"); end
      if (GLT_W < 1)                begin : g_bad_glt  $error("GLT_W must be at least 1");              end
      if (K_W < K_NEED)             begin : g_bad_k    $error("K_W too narrow for AVG_MAX_LOG2");       end
   endgenerate

   logic [NUM_CH-1:0]      beat_raw;
   logic [NUM_CH-1:0]      beat_rise;
   logic signed [TS_W-1:0] meas_word;
   logic                   meas_vld;

   assign beat_raw[CH_REF] = clk_ref_in;
   assign beat_raw[CH_LNK] = clk_lnk_in;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      ddmtd_beat_cond #(
         .SYNC_STAGES (SYNC_STAGES),
         .GLT_W       (GLT_W)
      ) u_cond (
         .clk         (clk_hlp),
         .rst_n       (rst_n),
         .beat_in     (beat_raw[c]),
         .cfg_run_len (cfg_glitch_len),
         .rise_o      (beat_rise[c])
      );
   end

   ddmtd_edge_pair #(
      .TS_W (TS_W)
   ) u_pair (
      .clk       (clk_hlp),
      .rst_n     (rst_n),
      .rise_ref  (beat_rise[CH_REF]),
      .rise_lnk  (beat_rise[CH_LNK]),
      .beat_len  (cfg_beat_len),
      .meas_word (meas_word),
      .meas_vld  (meas_vld)
   );

   ddmtd_avg #(
      .TS_W         (TS_W),
      .AVG_MAX_LOG2 (AVG_MAX_LOG2),
      .K_W          (K_W)
   ) u_avg (
      .clk      (clk_hlp),
      .rst_n    (rst_n),
      .in_word  (meas_word),
      .in_vld   (meas_vld),
      .cfg_k    (cfg_avg_log2),
      .out_word (phase_word),
      .out_vld  (phase_vld)
   );
endmodule

// File: rtl/ddmtd_phase_meter_chk.sv
module ddmtd_phase_meter_chk #(
   parameter int unsigned TS_W = 16
) (
   input logic                   clk_hlp,
   input logic                   rst_n,
   input logic [TS_W-1:0]        cfg_beat_len,
   input logic signed [TS_W-1:0] phase_word,
   input logic                   phase_vld,
   input logic                   meas_vld
);
   logic signed [TS_W:0] word_x;
   logic signed [TS_W:0] lo_x;
   logic signed [TS_W:0] hi_x;

   assign word_x = {phase_word[TS_W-1], phase_word};
   assign lo_x   = -$signed({1'b0, cfg_beat_len >> 1});
   assign hi_x   = $signed({1'b0, cfg_beat_len - (cfg_beat_len >> 1)});

   // R1: reset clears the output strobe and word
   a_r1_reset_quiet: assert property (@(posedge clk_hlp)
      !rst_n |=> (!phase_vld && phase_word == '0));

   // R5: strobe never lasts two cycles
   a_r5_single_pulse: assert property (@(posedge clk_hlp) disable iff (!rst_n)
      phase_vld |=> !phase_vld);

   // R4: every output lies inside the folded window
   a_r4_in_window: assert property (@(posedge clk_hlp) disable iff (!rst_n)
      phase_vld |-> (word_x >= lo_x && word_x < hi_x));

   // R7: an output always follows a fresh measurement
   a_r7_out_after_meas: assert property (@(posedge clk_hlp) disable iff (!rst_n)
      phase_vld |-> $past(meas_vld));
endmodule

bind ddmtd_phase_meter ddmtd_phase_meter_chk #(.TS_W(TS_W)) u_chk (
   .clk_hlp      (clk_hlp),
   .rst_n        (rst_n),
   .cfg_beat_len (cfg_beat_len),
   .phase_word   (phase_word),
   .phase_vld    (phase_vld),
   .meas_vld     (meas_vld)
);

// File: tb/ddmtd_phase_meter_tb_top.sv
module ddmtd_phase_meter_tb_top;
   localparam int TS_W  = 16;
   localparam int GLT_W = 4;
   localparam int K_W   = 3;
   localparam int P     = 64;

   logic                   clk = 1'b0;
   logic                   rst_n;
   logic                   sig_ref, sig_lnk;
   logic [GLT_W-1:0]       cfg_glitch_len;
   logic [K_W-1:0]         cfg_avg_log2;
   logic signed [TS_W-1:0] phase_word;
   logic                   phase_vld;

   int  n_chk  = 0;
   int  n_fail = 0;
   int  off0 = 0, off1 = 0;
   bit  ref_en = 1'b1;
   int  glitch_w = 0;

   always #4 clk = ~clk;

   ddmtd_phase_meter #(.TS_W(TS_W), .GLT_W(GLT_W), .K_W(K_W)) dut_i (
      .clk_hlp        (clk),
      .rst_n          (rst_n),
      .clk_ref_in     (sig_ref),
      .clk_lnk_in     (sig_lnk),
      .cfg_beat_len   (TS_W'(P)),
      .cfg_glitch_len (cfg_glitch_len),
      .cfg_avg_log2   (cfg_avg_log2),
      .phase_word     (phase_word),
      .phase_vld      (phase_vld)
   );

   // beat generator: reference rises at phase 0, link at phase cur_off
   initial begin
      int ph, cur_off, bp;
      bit alt;
      ph = 0; cur_off = 0; alt = 1'b0;
      sig_ref = 1'b0; sig_lnk = 1'b0;
      forever begin
         @(negedge clk);
         if (ph == 0) begin
            alt     = ~alt;
            cur_off = alt ? off0 : off1;
         end
         bp = (((ph - cur_off) % P) + P) % P;
         sig_ref = ref_en && (ph < P/2);
         if (glitch_w > 0 && ph >= 3*P/4 && ph < 3*P/4 + glitch_w) sig_ref = ref_en;
         sig_lnk = (bp < P/2);
         ph = (ph + 1) % P;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic get_word(input string req, output int w);
      bit got = 1'b0;
      w = 0;
      for (int i = 0; i < 40*P; i++) begin
         @(negedge clk);
         if (phase_vld) begin
            w = int'(phase_word);
            got = 1'b1;
            break;
         end
      end
      if (!got) chk(1'b0, {req, " no strobe"}, 0, 1);
   endtask

   task automatic count_pulses(input int cycles, output int n);
      n = 0;
      for (int i = 0; i < cycles; i++) begin
         @(negedge clk);
         if (phase_vld) n++;
      end
   endtask

   task automatic restart(input int o0, input int o1, input int k, input int n,
                          input bit ren, input int gw, input bit skip);
      int w;
      rst_n = 1'b0;
      off0 = o0; off1 = o1; cfg_avg_log2 = K_W'(k); cfg_glitch_len = GLT_W'(n);
      ref_en = ren; glitch_w = gw;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      if (skip) begin
         get_word("settle", w);
         get_word("settle", w);
      end
   endtask

   task automatic expect_words(input string req, input int cnt, input int exp);
      int w;
      for (int i = 0; i < cnt; i++) begin
         get_word(req, w);
         chk(w == exp, req, w, exp);
      end
   endtask

   task automatic t_reset;
      rst_n = 1'b0; cfg_avg_log2 = '0; cfg_glitch_len = GLT_W'(2);
      repeat (4) @(negedge clk);
      chk(phase_vld == 1'b0, "R1 vld", int'(phase_vld), 0);
      chk(phase_word == '0, "R1 word", int'(phase_word), 0);
   endtask

   task automatic t_positive;
      restart(5, 5, 0, 2, 1'b1, 0, 1'b1);  expect_words("R2 off5", 3, 5);
      restart(13, 13, 0, 2, 1'b1, 0, 1'b1); expect_words("R2 off13", 2, 13);
   endtask

   task automatic t_negative;
      restart(-7, -7, 0, 2, 1'b1, 0, 1'b1); expect_words("R3 off-7", 3, -7);
   endtask

   task automatic t_fold;
      restart(31, 31, 0, 2, 1'b1, 0, 1'b1);  expect_words("R4 sep31", 2, 31);
      restart(32, 32, 0, 2, 1'b1, 0, 1'b1);  expect_words("R4 sep32", 2, -32);
      restart(-32, -32, 0, 2, 1'b1, 0, 1'b1); expect_words("R4 sep-32", 1, -32);
   endtask

   task automatic t_rate;
      int n;
      restart(9, 9, 0, 2, 1'b1, 0, 1'b1);
      count_pulses(8*P, n);
      chk(n == 8, "R5 pulses per 8 periods", n, 8);
   endtask

   task automatic t_glitch;
      restart(-12, -12, 0, 4, 1'b1, 2, 1'b1); expect_words("R6 N4 glitch ignored", 2, -12);
      restart(-12, -12, 0, 1, 1'b1, 2, 1'b1); expect_words("R6 N1 glitch accepted", 2, 4);
   endtask

   task automatic t_avg;
      int n;
      restart(3, 5, 1, 2, 1'b1, 0, 1'b1); expect_words("R7 mean of 3,5", 2, 4);
      restart(3, 5, 2, 2, 1'b1, 0, 1'b1);
      count_pulses(8*P, n);
      chk(n == 2, "R7 k2 pulses per 8 periods", n, 2);
      restart(-3, -4, 1, 2, 1'b1, 0, 1'b1); expect_words("R8 floor mean", 2, -4);
   endtask

   task automatic t_unpaired;
      int n;
      restart(6, 6, 0, 2, 1'b0, 0, 1'b0);
      count_pulses(8*P, n);
      chk(n == 0, "R9 no ref edge", n, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      t_reset();
      t_positive();
      t_negative();
      t_fold();
      t_rate();
      t_glitch();
      t_avg();
      t_unpaired();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule